// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block runs on the host side of a parallel NOR flash. Once the host has issued a program or erase command sequence, the poller finds out when the operation has finished. It repeatedly reads a status address inside the target sector and looks at the completion bit (bit 7). For a program operation it compares that bit with the matching bit of the data that was written. For an erase operation it waits for that bit to read as one.

Two hazards shape the design. First, the read on which bit 7 first shows completion may still return stale values in the lower bits, so the poller always makes one more read and reports that byte. Second, the time-limit flag (bit 5) can be set at the same moment the operation finishes. The poller therefore treats that flag as provisional, reads once more, and declares a device failure only if bit 7 still shows the operation as unfinished.

A loop limit set by a parameter guards against an operation that never finishes. The caller must start the poller only after the full command sequence has been written: 4 write strobes for a program, 6 for an erase. The poll address must lie in a sector that is being written or erased and that is not protected.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o` and `fail_o` are all low.
- R2: A `start_i` pulse seen while idle raises `busy_o` and `rd_req_o` in the next cycle. Every read of that operation uses the `poll_addr_i` value captured at start.
- R3: For a program operation (`op_erase_i` = 0), a status read counts as complete when its bit 7 equals bit 7 of `exp_data_i`.
- R4: For an erase operation (`op_erase_i` = 1), a status read counts as complete when its bit 7 is 1.
- R5: After the first complete read, exactly one further read is made. `done_o` then pulses, and `rdata_o` holds the byte returned by that further read.
- R6: An incomplete read with bit 5 set triggers one confirmation read. If that read is complete, the final read of R5 follows. Otherwise `fail_o` pulses with `fail_code_o` = 1 (device time limit).
- R7: If `MAX_POLLS` status reads are all incomplete and none has bit 5 set, `fail_o` pulses with `fail_code_o` = 2 (poll limit), and no further read is made.
- R8: A `start_i` pulse while busy is ignored. The captured address and operation type do not change.
- R9: On a read that is complete and also has bit 5 set, completion takes priority and no confirmation read is made.
- R10: `done_o` and `fail_o` are single-cycle pulses that are never high together. `busy_o` is low in the cycle either one is high.
- R11: `rd_req_o` stays high until `rd_ack_i` is seen. A read completes only in a cycle where both are high, with `rd_data_i` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (taken only when idle) |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| exp_data_i | input | DATA_W | Byte that was programmed (only bit 7 is used) |
| poll_addr_i | input | ADDR_W | Status address inside the target sector |
| rd_req_o | output | 1 | Read request to the flash bus |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read completes this cycle |
| rd_data_i | input | DATA_W | Read data, valid with `rd_ack_i` |
| busy_o | output | 1 | An operation is being polled |
| done_o | output | 1 | Success pulse |
| rdata_o | output | DATA_W | Final byte read, valid with `done_o` |
| fail_o | output | 1 | Failure pulse |
| fail_code_o | output | 2 | 1 = device time limit, 2 = poll limit |

## Verification
The bench feeds scripted status sequences for both operation types, including patterns in which bit 5 is set while bit 7 is already complete. A design that checked bit 5 first would make an extra confirmation read, so the read count it reports would be wrong. A design that reported on the first complete read would return the stale byte rather than the final byte. A design that confirmed bit 5 without re-checking bit 7 would report a device failure where the operation had in fact succeeded.

Other cases exercise the poll limit, a start pulse arriving mid-operation, and bus reads with zero, one and two wait cycles. A poller that latched the second start would move its read address, or would apply the erase rule to a program operation.

// File: rtl/poll_pkg.sv
package poll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_POLL    = 2'd1,
      ST_CONFIRM = 2'd2,
      ST_FINAL   = 2'd3
   } poll_state_t;

   typedef enum logic [1:0] {
      FAIL_NONE   = 2'd0,
      FAIL_DEVICE = 2'd1,
      FAIL_LIMIT  = 2'd2
   } fail_code_t;

endpackage

// File: rtl/poll_req_latch.sv
module poll_req_latch #(
   parameter int ADDR_W = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              erase_i,
   input  logic              exp_bit_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              erase_q,
   output logic              exp_bit_q,
   output logic [ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         erase_q   <= 1'b0;
         exp_bit_q <= 1'b0;
         addr_q    <= '0;
      end else if (load_i) begin
         erase_q   <= erase_i;
         exp_bit_q <= exp_bit_i;
         addr_q    <= addr_i;
      end
   end

endmodule

// File: rtl/poll_status_eval.sv
module poll_status_eval #(
   parameter int DATA_W    = 8,
   parameter int DONE_BIT  = 7,
   parameter int LIMIT_BIT = 5
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              erase_i,
   input  logic              exp_bit_i,
   output logic              complete_o,
   output logic              limit_flag_o
);

   logic done_bit;
   logic unused_data;

   generate
      if (DONE_BIT >= DATA_W || LIMIT_BIT >= DATA_W) begin : g_bad_pos
         $error("status bit positions must lie inside DATA_W");
      end
      if (DONE_BIT == LIMIT_BIT) begin : g_same_pos
         $error("completion and limit bits must differ");
      end
   endgenerate

   assign done_bit     = data_i[DONE_BIT];
   assign complete_o   = erase_i ? done_bit : (done_bit == exp_bit_i);
   assign limit_flag_o = data_i[LIMIT_BIT];
   assign unused_data  = ^data_i;

endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
   parameter int MAX_POLLS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic last_o
);

   generate
      if (MAX_POLLS < 0) begin : g_bad_limit
         $error("MAX_POLLS must not be negative");
      end
      if (MAX_POLLS == 0) begin : g_unbounded
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clear_i ^ step_i;
         assign last_o    = 1'b0;
      end else begin : g_bounded
         localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
         localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clear_i) cnt_q <= '0;
            else if (step_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end
         assign last_o = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
   import poll_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int DATA_W    = 8,
   parameter int DONE_BIT  = 7,
   parameter int LIMIT_BIT = 5,
   parameter int MAX_POLLS = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_erase_i,
   input  logic [DATA_W-1:0] exp_data_i,
   input  logic [ADDR_W-1:0] poll_addr_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              fail_o,
   output logic [1:0]        fail_code_o
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   poll_state_t st_q, st_d;
   logic        load, clear_cnt, step_cnt;
   logic        done_set, fail_set;
   fail_code_t  code_d;
   logic        op_erase_q, exp_bit_q;
   logic        complete, limit_flag, budget_last;
   logic        unused_exp;

   assign unused_exp = ^exp_data_i;

   poll_req_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .erase_i  (op_erase_i),
      .exp_bit_i(exp_data_i[DONE_BIT]),
      .addr_i   (poll_addr_i),
      .erase_q  (op_erase_q),
      .exp_bit_q(exp_bit_q),
      .addr_q   (rd_addr_o)
   );

   poll_status_eval #(
      .DATA_W   (DATA_W),
      .DONE_BIT (DONE_BIT),
      .LIMIT_BIT(LIMIT_BIT)
   ) u_eval (
      .data_i      (rd_data_i),
      .erase_i     (op_erase_q),
      .exp_bit_i   (exp_bit_q),
      .complete_o  (complete),
      .limit_flag_o(limit_flag)
   );

   poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(clear_cnt),
      .step_i (step_cnt),
      .last_o (budget_last)
   );

   always_comb begin
      st_d      = st_q;
      load      = 1'b0;
      clear_cnt = 1'b0;
      step_cnt  = 1'b0;
      done_set  = 1'b0;
      fail_set  = 1'b0;
      code_d    = FAIL_NONE;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               load      = 1'b1;
               clear_cnt = 1'b1;
               st_d      = ST_POLL;
            end
         end
         ST_POLL: begin
            if (rd_ack_i) begin
               if (complete) begin
                  st_d = ST_FINAL;
               end else if (limit_flag) begin
                  st_d = ST_CONFIRM;
               end else if (budget_last) begin
                  st_d     = ST_IDLE;
                  fail_set = 1'b1;
                  code_d   = FAIL_LIMIT;
               end else begin
                  step_cnt = 1'b1;
               end
            end
         end
         ST_CONFIRM: begin
            if (rd_ack_i) begin
               if (complete) begin
                  st_d = ST_FINAL;
               end else begin
                  st_d     = ST_IDLE;
                  fail_set = 1'b1;
                  code_d   = FAIL_DEVICE;
               end
            end
         end
         ST_FINAL: begin
            if (rd_ack_i) begin
               st_d     = ST_IDLE;
               done_set = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         done_o      <= 1'b0;
         fail_o      <= 1'b0;
         fail_code_o <= FAIL_NONE;
         rdata_o     <= '0;
      end else begin
         st_q   <= st_d;
         done_o <= done_set;
         fail_o <= fail_set;
         if (fail_set) fail_code_o <= code_d;
         if (done_set) rdata_o     <= rd_data_i;
      end
   end

   assign rd_req_o = (st_q != ST_IDLE);
   assign busy_o   = (st_q != ST_IDLE);

endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
   parameter int ADDR_W    = 22,
   parameter int MAX_POLLS = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_ack_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              fail_o
);

   int unsigned reads_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy_o) reads_q <= 0;
      else if (rd_req_o && rd_ack_i) reads_q <= reads_q + 1;
   end

   // R1
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o);

   // R2
   start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && rd_req_o));

   // R5
   done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(rd_req_o && rd_ack_i));

   // R7
   read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (MAX_POLLS > 0 && busy_o) |-> (reads_q <= MAX_POLLS + 2));

   // R8
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

   // R10
   one_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fail_o));

   // R10
   report_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |-> !busy_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> rd_req_o);

endmodule

bind flash_done_poller flash_done_poller_chk #(
   .ADDR_W   (ADDR_W),
   .MAX_POLLS(MAX_POLLS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .rd_req_o (rd_req_o),
   .rd_addr_o(rd_addr_o),
   .rd_ack_i (rd_ack_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .fail_o   (fail_o)
);

// File: tb/flash_done_poller_test.sv
`timescale 1ns/1ps
module flash_done_poller_test;

   localparam int AW = 22;
   localparam int DW = 8;
   localparam int NP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          op_erase_i = 1'b0;
   logic [DW-1:0] exp_data_i = '0;
   logic [AW-1:0] poll_addr_i = '0;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_ack_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;
   logic          busy_o, done_o, fail_o;
   logic [DW-1:0] rdata_o;
   logic [1:0]    fail_code_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit all_done = 1'b0;

   always #5 clk = ~clk;

   flash_done_poller #(
      .ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(NP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
      .exp_data_i(exp_data_i), .poll_addr_i(poll_addr_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
      .rdata_o(rdata_o), .fail_o(fail_o), .fail_code_o(fail_code_o)
   );

   typedef struct packed {
      logic        er;
      logic [7:0]  ex;
      logic [47:0] rs;     // byte i of script at [8*i +: 8]
      logic [2:0]  nr;
      logic [1:0]  lat;
      logic        want_fail;
      logic [1:0]  code;
      logic [7:0]  data;
      logic [3:0]  reads;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'hA5, {8'h00,8'h00,8'hA5,8'h85,8'h05,8'h05}, 3'd4, 2'd0, 1'b0, 2'd0, 8'hA5, 4'd4},
      '{1'b0, 8'h3C, {8'h00,8'h00,8'h00,8'h3C,8'h1F,8'h9C}, 3'd3, 2'd1, 1'b0, 2'd0, 8'h3C, 4'd3},
      '{1'b1, 8'h00, {8'h00,8'h00,8'hFF,8'h80,8'h00,8'h00}, 3'd4, 2'd2, 1'b0, 2'd0, 8'hFF, 4'd4},
      '{1'b1, 8'h00, {8'h00,8'h00,8'h00,8'hFF,8'h80,8'h20}, 3'd3, 2'd0, 1'b0, 2'd0, 8'hFF, 4'd3},
      '{1'b1, 8'h00, {8'h00,8'h00,8'h00,8'h00,8'h20,8'h20}, 3'd2, 2'd1, 1'b1, 2'd1, 8'h00, 4'd2},
      '{1'b0, 8'h80, {8'h00,8'h00,8'h00,8'h00,8'h80,8'hA0}, 3'd2, 2'd0, 1'b0, 2'd0, 8'h80, 4'd2},
      '{1'b1, 8'h00, {8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 3'd1, 2'd0, 1'b1, 2'd2, 8'h00, 4'd6},
      '{1'b0, 8'h00, {8'h00,8'h00,8'h00,8'h00,8'h11,8'h00}, 3'd2, 2'd2, 1'b0, 2'd0, 8'h11, 4'd2},
      '{1'b0, 8'h80, {8'h00,8'h00,8'h00,8'h00,8'h00,8'h20}, 3'd2, 2'd0, 1'b1, 2'd1, 8'h00, 4'd2}
   };

   function automatic string vec_tag(input int i);
      case (i)
         0: return "R3";
         1: return "R3";
         2: return "R4";
         3: return "R6";
         4: return "R6";
         5: return "R9";
         6: return "R7";
         7: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic run_op(input logic er, input logic [7:0] ex, input logic [AW-1:0] ad,
                         input logic [47:0] rs, input int nr, input int lat,
                         output int reads, output bit got_done, output bit got_fail,
                         output logic [1:0] code, output logic [7:0] data,
                         output bit addr_ok);
      int idx = 0;
      int wt = 0;
      int cyc = 0;
      bit fin = 1'b0;
      reads = 0; got_done = 0; got_fail = 0; code = '0; data = '0; addr_ok = 1'b1;
      @(negedge clk);
      start_i = 1'b1; op_erase_i = er; exp_data_i = ex; poll_addr_i = ad;
      @(negedge clk);
      start_i = 1'b0;
      // R2: request raised the cycle after start
      check(busy_o && rd_req_o, "R2", "launch", {busy_o, rd_req_o}, 2'b11);
      while (!fin && cyc < 200) begin
         if (done_o || fail_o) begin
            got_done = done_o; got_fail = fail_o;
            code = fail_code_o; data = rdata_o;
            fin = 1'b1;
            rd_ack_i = 1'b0;
         end else if (rd_req_o) begin
            if (rd_addr_o != ad) addr_ok = 1'b0;
            if (wt >= lat) begin
               rd_ack_i  = 1'b1;
               rd_data_i = rs[8*((idx < nr) ? idx : nr-1) +: 8];
               idx++;
               reads++;
               wt = 0;
            end else begin
               rd_ack_i = 1'b0;
               wt++;
            end
         end else begin
            rd_ack_i = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      // R10: report lasts one cycle
      check(!done_o && !fail_o, "R10", "pulse width", {done_o, fail_o}, 2'b00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!all_done) begin
         n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int reads;
      bit gd, gf, aok;
      logic [1:0] cd;
      logic [7:0] dt;

      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy_o && !rd_req_o && !done_o && !fail_o, "R1", "reset outputs",
            {busy_o, rd_req_o, done_o, fail_o}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !rd_req_o, "R1", "idle after reset", {busy_o, rd_req_o}, 2'b00);

      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].er, VECS[i].ex, AW'(22'h10000 + i * 22'h0123), VECS[i].rs,
                int'(VECS[i].nr), int'(VECS[i].lat), reads, gd, gf, cd, dt, aok);
         check(aok, "R2", "read address", 32'(aok), 32'd1);
         check(gd == !VECS[i].want_fail && gf == VECS[i].want_fail, vec_tag(i),
               "outcome done/fail", {gd, gf}, {!VECS[i].want_fail, VECS[i].want_fail});
         check(reads == int'(VECS[i].reads), VECS[i].want_fail ? vec_tag(i) : "R5",
               "read count", reads, VECS[i].reads);
         if (VECS[i].want_fail)
            check(cd == VECS[i].code, vec_tag(i), "fail code", cd, VECS[i].code);
         else
            check(dt == VECS[i].data, "R5", "final byte", dt, VECS[i].data);
      end

      // R8 and R11: second start ignored, request held without ack
      @(negedge clk);
      start_i = 1'b1; op_erase_i = 1'b0; exp_data_i = 8'h00; poll_addr_i = 22'h2AAAA;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      check(rd_req_o, "R11", "request held", 32'(rd_req_o), 32'd1);
      start_i = 1'b1; op_erase_i = 1'b1; poll_addr_i = 22'h15555;
      @(negedge clk);
      start_i = 1'b0;
      check(rd_req_o, "R11", "request held 2", 32'(rd_req_o), 32'd1);
      @(negedge clk);
      check(rd_addr_o == 22'h2AAAA, "R8", "address kept", rd_addr_o, 22'h2AAAA);
      // 0x00 is complete for program with bit 7 = 0, not for erase
      rd_ack_i = 1'b1; rd_data_i = 8'h00;
      @(negedge clk);
      rd_data_i = 8'h5A;
      @(negedge clk);
      rd_ack_i = 1'b0;
      check(done_o && rdata_o == 8'h5A, "R8", "program rule kept",
            {done_o, rdata_o}, {1'b1, 8'h5A});
      @(negedge clk);
      check(!busy_o && !rd_req_o, "R10", "idle after report", {busy_o, rd_req_o}, 2'b00);

      all_done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule